// File: doc/BRIEF.md
# Dual Bit-Serial Inner Product Unit

This block forms a signed inner product of a weight vector and an activation vector. Both operands reach it one bit at a time. A weight bit-plane holds one bit of every lane's weight. It is latched once. Every activation bit-plane for that weight bit then streams in, one plane per cycle. Each lane ANDs its weight bit with its activation bit. An adder tree counts the ones across the lanes. The count is shifted by the sum of the two bit indices and added to a wide accumulator, or subtracted from it when the weight bit is the sign bit.

Weight and activation precisions are chosen for each job at `start`, from 1 to `MAXP` bits each. One result therefore costs Pw×Pa accumulation cycles, plus one load cycle per weight plane. Narrow operands finish proportionally sooner. The unit is meant to be tiled into a larger array. The surrounding logic feeds the planes and collects the result when `done` pulses.

Top module: `dbs_inner_product`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` while idle captures the precisions as Pw = `pw_m1`+1 and Pa = `pa_m1`+1 (each 1 to MAXP). It raises `busy` and clears `result` to 0 at the next clock edge.
- R3: A `start` while `busy` is high is ignored. It changes neither the precisions nor the job in progress.
- R4: Weight planes are expected from the most significant bit down to bit 0. One plane is accepted per `w_load` while the unit is waiting for a weight plane. Bit j of `w_plane` is the current weight bit of lane j.
- R5: After each accepted weight plane, exactly Pa activation planes are accepted through `a_valid`, from bit 0 upward. Bit j of `a_plane` is the current activation bit of lane j.
- R6: When the job ends, `result` equals the sum over lanes of w_j×a_j. Each w_j is a Pw-bit two's complement number and each a_j is a Pa-bit unsigned number.
- R7: `done` is high for one cycle only. It rises, and `busy` falls, in the cycle after the Pw×Pa-th accepted activation plane.
- R8: While the unit is idle, `result` keeps its value until the next accepted `start`.
- R9: The accumulator is 2·MAXP+clog2(LANES)+1 bits wide. With all lanes at the most negative or the most positive weight and the largest activation, at full precision, it returns the exact result.
- R10: `a_valid` while waiting for a weight plane and `w_load` during the activation phase are ignored and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; accepted only while idle |
| pw_m1 | input | PW_W | Weight precision minus one |
| pa_m1 | input | PW_W | Activation precision minus one |
| w_load | input | 1 | Weight plane strobe |
| w_plane | input | LANES | One weight bit per lane |
| a_valid | input | 1 | Activation plane valid |
| a_plane | input | LANES | One activation bit per lane |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| result | output | ACC_W | Signed inner product |

## Verification
There are two kinds of control error. An off-by-one in the plane counters shows up as `done` arriving a cycle early or late. A sign plane applied to the wrong weight bit shows up in `result`, which is wrong by a large power-of-two multiple. The bench compares `busy` and `done` against its reference model on every clock, so a counter fault is reported within one cycle of the missed transition. A fault in the weight register, the adder tree or the shift amount is only visible at the end of the job, when the final `result` is checked against an integer dot product. Junk strobes and a `start` while busy are injected mid-job, so a phase decoder that accepts them corrupts that same final check.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT_W = 2'd1,
      ST_ACT    = 2'd2
   } dbs_state_e;
endpackage

// File: rtl/dbs_lane_array.sv
module dbs_lane_array #(
   parameter int LANES = 16,
   localparam int SUM_W = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [LANES-1:0] w_plane,
   input  logic [LANES-1:0] a_plane,
   output logic [SUM_W-1:0] partial
);
   logic [LANES-1:0] w_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_bits <= '0;
      else if (capture) w_bits <= w_plane;
   end

   if (LANES < 1) begin : g_bad_lanes
      $error("dbs_lane_array: LANES must be at least 1");
   end

   if (LANES == 1) begin : g_single
      assign partial = SUM_W'(w_bits[0] & a_plane[0]);
   end else begin : g_tree
      // heap layout: node n has children 2n+1 and 2n+2, leaves at LANES-1+i
      logic [SUM_W-1:0] node [2*LANES-1];
      for (genvar i = 0; i < LANES; i++) begin : g_leaf
         assign node[LANES-1+i] = SUM_W'(w_bits[i] & a_plane[i]);
      end
      for (genvar n = 0; n < LANES-1; n++) begin : g_add
         assign node[n] = node[2*n+1] + node[2*n+2];
      end
      assign partial = node[0];
   end

   assert_partial_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(partial) <= LANES);
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
   import dbs_pkg::*;
#(
   parameter int MAXP = 16,
   localparam int PW_W = $clog2(MAXP),
   localparam int SH_W = $clog2(2*MAXP - 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [PW_W-1:0] pw_m1,
   input  logic [PW_W-1:0] pa_m1,
   input  logic            w_load,
   input  logic            a_valid,
   output logic            clr,
   output logic            w_capture,
   output logic            step,
   output logic            neg,
   output logic [SH_W-1:0] shamt,
   output logic            busy,
   output logic            done
);
   dbs_state_e      state;
   logic [PW_W-1:0] pw_r, pa_r, wbit, abit;

   if (MAXP < 2) begin : g_bad_maxp
      $error("dbs_ctrl: MAXP must be at least 2");
   end

   assign busy      = (state != ST_IDLE);
   assign clr       = (state == ST_IDLE) && start;
   assign w_capture = (state == ST_WAIT_W) && w_load;
   assign step      = (state == ST_ACT) && a_valid;
   assign neg       = (wbit == pw_r);
   assign shamt     = SH_W'(wbit) + SH_W'(abit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pw_r  <= '0;
         pa_r  <= '0;
         wbit  <= '0;
         abit  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               pw_r  <= pw_m1;
               pa_r  <= pa_m1;
               wbit  <= pw_m1;
               abit  <= '0;
               state <= ST_WAIT_W;
            end
            ST_WAIT_W: if (w_load) begin
               abit  <= '0;
               state <= ST_ACT;
            end
            ST_ACT: if (a_valid) begin
               if (abit == pa_r) begin
                  if (wbit == '0) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     wbit  <= wbit - 1'b1;
                     state <= ST_WAIT_W;
                  end
               end else begin
                  abit <= abit + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(pw_r) && $stable(pa_r)));
   assert_abit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (abit <= pa_r && wbit <= pw_r));
endmodule

// File: rtl/dbs_accum.sv
module dbs_accum #(
   parameter int SUM_W = 5,
   parameter int SH_W  = 5,
   parameter int ACC_W = 37
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   input  logic                    neg,
   input  logic [SH_W-1:0]         shamt,
   input  logic [SUM_W-1:0]        partial,
   output logic signed [ACC_W-1:0] acc
);
   logic [ACC_W:0] term, ext;

   assign term = (ACC_W+1)'(partial) << shamt;
   assign ext  = neg ? ({acc[ACC_W-1], acc} - term) : ({acc[ACC_W-1], acc} + term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (step) acc <= ext[ACC_W-1:0];
   end

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (ext[ACC_W] == ext[ACC_W-1]));
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(acc));
endmodule

// File: rtl/dbs_inner_product.sv
module dbs_inner_product #(
   parameter int LANES = 16,
   parameter int MAXP  = 16,
   localparam int PW_W  = $clog2(MAXP),
   localparam int SUM_W = $clog2(LANES + 1),
   localparam int SH_W  = $clog2(2*MAXP - 1),
   localparam int ACC_W = 2*MAXP + $clog2(LANES) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [PW_W-1:0]         pw_m1,
   input  logic [PW_W-1:0]         pa_m1,
   input  logic                    w_load,
   input  logic [LANES-1:0]        w_plane,
   input  logic                    a_valid,
   input  logic [LANES-1:0]        a_plane,
   output logic                    busy,
   output logic                    done,
   output logic signed [ACC_W-1:0] result
);
   logic            clr, w_capture, step, neg;
   logic [SH_W-1:0]  shamt;
   logic [SUM_W-1:0] partial;

   dbs_ctrl #(.MAXP(MAXP)) i_ctrl (
      .clk, .rst_n, .start, .pw_m1, .pa_m1, .w_load, .a_valid,
      .clr, .w_capture, .step, .neg, .shamt, .busy, .done
   );

   dbs_lane_array #(.LANES(LANES)) i_lanes (
      .clk, .rst_n, .capture(w_capture), .w_plane, .a_plane, .partial
   );

   dbs_accum #(.SUM_W(SUM_W), .SH_W(SH_W), .ACC_W(ACC_W)) i_accum (
      .clk, .rst_n, .clr, .step, .neg, .shamt, .partial, .acc(result)
   );
endmodule

// File: tb/test_dbs_inner_product.sv
module test_dbs_inner_product;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 16;
   localparam int MAXP  = 16;

   logic               clk = 0, rst_n = 0;
   logic               start = 0, w_load = 0, a_valid = 0;
   logic [3:0]         pw_m1 = 0, pa_m1 = 0;
   logic [LANES-1:0]   w_plane = 0, a_plane = 0;
   logic               busy, done;
   logic signed [36:0] result;

   int checks = 0, fails = 0, cyc = 0;
   int cur_w [LANES];
   int cur_a [LANES];

   // behavioural reference state
   int     m_phase = 0, m_wleft = 0, m_aleft = 0, m_pw = 1, m_pa = 1;
   bit     m_done = 0;
   longint m_res = 0;

   dbs_inner_product #(.LANES(LANES), .MAXP(MAXP)) i_dbs_inner_product (
      .clk, .rst_n, .start, .pw_m1, .pa_m1, .w_load, .w_plane,
      .a_valid, .a_plane, .busy, .done, .result
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic longint dot();
      longint s = 0;
      for (int j = 0; j < LANES; j++) s += longint'(cur_w[j]) * longint'(cur_a[j]);
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_done = 0; m_res = 0;
      end else begin
         m_done = 0;
         case (m_phase)
            0: if (start) begin
               m_phase = 1; m_pw = int'(pw_m1) + 1; m_pa = int'(pa_m1) + 1;
               m_wleft = m_pw; m_res = 0;
            end
            1: if (w_load) begin m_phase = 2; m_aleft = m_pa; end
            default: if (a_valid) begin
               m_aleft--;
               if (m_aleft == 0) begin
                  m_wleft--;
                  if (m_wleft == 0) begin m_phase = 0; m_done = 1; m_res = dot(); end
                  else m_phase = 1;
               end
            end
         endcase
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         check(busy == (m_phase != 0), "R7 busy", longint'(busy), longint'(m_phase != 0));
         check(done == m_done, "R7 done", longint'(done), longint'(m_done));
         if (m_phase == 0)
            check(longint'(result) == m_res, "R8 idle result", longint'(result), m_res);
      end
      if (cyc == 150000) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic run(input int pw, input int pa, input int mode, input bit junk);
      for (int j = 0; j < LANES; j++) begin
         case (mode)
            1: begin cur_w[j] = -(1 << (pw-1)); cur_a[j] = (1 << pa) - 1; end
            2: begin cur_w[j] = (1 << (pw-1)) - 1; cur_a[j] = (1 << pa) - 1; end
            default: begin
               cur_w[j] = int'($urandom_range(0, (1 << pw) - 1)) - (1 << (pw-1));
               cur_a[j] = int'($urandom_range(0, (1 << pa) - 1));
            end
         endcase
      end
      @(negedge clk);
      start = 1; pw_m1 = 4'(pw-1); pa_m1 = 4'(pa-1);
      @(negedge clk);
      start = 0;
      check(busy == 1'b1 && result == 0, "R2 start clears", longint'(result), 0);
      for (int wb = pw-1; wb >= 0; wb--) begin
         if (junk) begin  // R10: activation strobe while waiting for weights
            a_valid = 1; a_plane = '1;
            @(negedge clk);
            a_valid = 0;
         end
         for (int j = 0; j < LANES; j++) w_plane[j] = cur_w[j][wb];
         w_load = 1;
         @(negedge clk);
         w_load = 0;
         for (int ab = 0; ab < pa; ab++) begin
            for (int j = 0; j < LANES; j++) a_plane[j] = cur_a[j][ab];
            a_valid = 1;
            if (junk && ab == 0) begin  // R10 stray weight strobe, R3 start while busy
               w_load = 1; w_plane = '1; start = 1; pw_m1 = 4'(pw % 16); pa_m1 = 4'((pa+3) % 16);
            end
            @(negedge clk);
            w_load = 0; start = 0;
         end
         a_valid = 0;
      end
      check(done == 1'b1, "R7 done after last plane", longint'(done), 1);
      check(longint'(result) == dot(), "R6 dot product", longint'(result), dot());
      @(negedge clk);
      @(negedge clk);
      check(longint'(result) == dot(), "R8 held", longint'(result), dot());
   endtask

   initial begin
      rst_n = 0;
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && result == 0, "R1 reset", longint'(result), 0);
      rst_n = 1;
      run(1, 1, 0, 0);     // R4 R5 minimum precisions
      run(16, 16, 1, 0);   // R9 most negative extreme
      run(16, 16, 2, 0);   // R9 most positive extreme
      run(16, 1, 0, 0);
      run(1, 16, 0, 1);
      run(4, 4, 1, 1);
      for (int k = 0; k < 20; k++)
         run(int'($urandom_range(1, 16)), int'($urandom_range(1, 16)), 0, k[0]);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule